// File: doc/BRIEF.md
# Multiplexed LCD Drive Sequencer

This block sequences a multiplexed segment LCD. It scans a programmable number of common (backplane) phases. For every output pin it produces a 3-bit code that selects one of six analog bias levels, V0 to V5, where V0 is the highest and V5 is ground. A per-pin role bit decides at run time whether a pin is a common line or a segment line. Common pins take common indices in ascending pin order. The lowest-numbered common pin is common 0, the next one is common 1, and so on.

Frame data is pulled with a request/acknowledge pair, so a DMA-style engine can refill it without processor involvement. An acknowledged frame waits in a shadow buffer. It moves to the active buffer only at the next frame boundary. The drive polarity alternates on every frame, which keeps the net DC component on each pin at zero. An invert input produces a negative image. If a frame is not delivered in time, the block keeps showing the old frame and sets a sticky underrun flag.

An acknowledge that arrives in the same cycle as a frame boundary is treated as arriving just before that boundary. Its data goes straight to the active buffer.

Top module: `lcd_mux_seq`

## Requirements
- R1: After reset the block is in the following state:
  - `phase` = 0 and `polarity` = 0.
  - `data_req` = 1 and `underrun` = 0.
  - The displayed frame is all zero, so every segment pin drives code 3.
  - The first common pin drives code 0 and every other common pin drives code 4.
- R2: `phase` advances by one every `prescale`+1 clock cycles. After the value `com_last` it wraps to 0.
- R3: `polarity` toggles at every wrap of `phase`. This means it toggles exactly once every (`prescale`+1)×(`com_last`+1) cycles.
- R4: The k-th common pin (k counted from 0 in ascending pin order) is selected when `phase` = k and k ≤ `com_last`.
  - A selected common drives code 0 when `polarity` = 0 and code 5 when `polarity` = 1.
  - An unselected common drives code 4 when `polarity` = 0 and code 1 when `polarity` = 1.
  - A common with k > `com_last` is never selected.
- R5: A segment pin p shows pixel bit `frame_data`[p×MAXCOM + `phase`] of the displayed frame.
  - An on pixel drives code 5 when `polarity` = 0 and code 0 when `polarity` = 1.
  - An off pixel drives code 3 when `polarity` = 0 and code 2 when `polarity` = 1.
- R6: While `invert` = 1, every segment pixel is complemented. Common pins are unaffected.
- R7: `data_req` rises in the cycle after each frame boundary. It stays high until a cycle in which `data_ack` = 1, and then falls.
- R8: A frame acknowledged during a frame is not displayed until the next frame boundary. The display keeps the current frame until then.
- R9: If a boundary arrives with no frame acknowledged since the previous boundary, the displayed frame is kept and `underrun` goes to 1. `underrun` stays at 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_is_com | input | NPINS | Role per pin: 1 = common, 0 = segment |
| com_last | input | log2(MAXCOM) | Number of commons minus one |
| prescale | input | PW | Clock cycles per phase minus one |
| invert | input | 1 | Complement segment pixels |
| data_ack | input | 1 | Frame data valid, accepted while `data_req` is high |
| frame_data | input | NPINS×MAXCOM | Frame pixels, bit p×MAXCOM+c for pin p in phase c |
| pin_level | output | NPINS×3 | Bias level code per pin, pin p at bits 3p+2:3p |
| phase | output | log2(MAXCOM) | Current common phase |
| polarity | output | 1 | Current frame polarity |
| data_req | output | 1 | Request for the next frame |
| underrun | output | 1 | Sticky missed-frame flag |

## Verification
The hardest situation to reach is an underrun that follows a frame that was already buffered. The shadow buffer is full at the first missed boundary, so no flag appears there. The flag appears only one boundary later. The bench runs an acknowledge responder that answers every request. It then stops the responder immediately after it has answered one request, and walks two boundaries while changing `frame_data`. This shows that the old image stays on the pins and that the flag survives later, successful frames.

// File: rtl/lcdseq_pkg.sv
// Shared types for the LCD drive sequencer: bias level codes and the
// level-selection rules for common and segment pins.
package lcdseq_pkg;

    localparam int LVL_W = 3;

    typedef enum logic [LVL_W-1:0] {
        LV_V0 = 3'd0,
        LV_V1 = 3'd1,
        LV_V2 = 3'd2,
        LV_V3 = 3'd3,
        LV_V4 = 3'd4,
        LV_V5 = 3'd5
    } lvl_e;

    // Level of a common line: extreme when selected, inner level otherwise.
    function automatic lvl_e com_level(input logic sel, input logic pol);
        if (!pol) return sel ? LV_V0 : LV_V4;
        else      return sel ? LV_V5 : LV_V1;
    endfunction

    // Level of a segment line: opposite extreme when on, middle level when off.
    function automatic lvl_e seg_level(input logic on, input logic pol);
        if (!pol) return on ? LV_V5 : LV_V3;
        else      return on ? LV_V0 : LV_V2;
    endfunction

endpackage

// File: rtl/lcdseq_timebase.sv
// Phase timebase: a prescaler divides the clock into phase ticks, a phase
// counter walks the commons, and the frame polarity flips at each wrap.
// Assumes: prescale and com_last may change at any time; a phase counter
// above com_last wraps on its next tick.
module lcdseq_timebase #(
    parameter int CW = 4,
    parameter int PW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] com_last,
    input  logic [PW-1:0] prescale,
    output logic [CW-1:0] phase,
    output logic          pol,
    output logic          frame_end
);

    logic [PW-1:0] cnt;
    logic          tick;

    assign tick      = (cnt >= prescale);
    assign frame_end = tick && (phase >= com_last);

    // Advance the prescaler, the phase counter and the polarity.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt   <= '0;
            phase <= '0;
            pol   <= 1'b0;
        end else if (tick) begin
            cnt <= '0;
            if (frame_end) begin
                phase <= '0;
                pol   <= ~pol;
            end else begin
                phase <= phase + 1'b1;
            end
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/lcdseq_framebuf.sv
// Double-buffered frame store with a request/acknowledge fetch.
// - An acknowledged frame lands in the shadow buffer.
// - At a boundary the shadow frame becomes active. An acknowledge in the
//   boundary cycle itself goes straight to the active buffer.
// - A boundary with nothing pending keeps the active frame and sets underrun.
// Assumes: frame_data is valid in the cycle data_ack is high.
module lcdseq_framebuf #(
    parameter int FB = 128
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frame_end,
    input  logic          data_ack,
    input  logic [FB-1:0] frame_data,
    output logic [FB-1:0] active,
    output logic          data_req,
    output logic          underrun
);

    logic [FB-1:0] shadow;
    logic          shadow_full;
    logic          take;

    assign take = data_req && data_ack;

    // Capture requested data and hand it to the display at frame boundaries.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active      <= '0;
            shadow      <= '0;
            shadow_full <= 1'b0;
            data_req    <= 1'b1;
            underrun    <= 1'b0;
        end else if (frame_end) begin
            data_req    <= 1'b1;
            shadow_full <= 1'b0;
            if (take)             active   <= frame_data;
            else if (shadow_full) active   <= shadow;
            else                  underrun <= 1'b1;
        end else if (take) begin
            shadow      <= frame_data;
            shadow_full <= 1'b1;
            data_req    <= 1'b0;
        end
    end

endmodule

// File: rtl/lcdseq_pindrive.sv
// Per-pin level selection. Common pins are numbered by their rank among the
// common pins (lowest pin first). Segment pins read their pixel for the
// current phase from the active frame, optionally inverted.
// Assumes: MAXCOM is a power of two.
module lcdseq_pindrive
    import lcdseq_pkg::*;
#(
    parameter int NPINS  = 8,
    parameter int MAXCOM = 16,
    parameter int CW     = 4
) (
    input  logic [NPINS-1:0]        pin_is_com,
    input  logic [CW-1:0]           com_last,
    input  logic [CW-1:0]           phase,
    input  logic                    pol,
    input  logic                    invert,
    input  logic [NPINS*MAXCOM-1:0] active,
    output logic [NPINS*LVL_W-1:0]  pin_level
);

    localparam int RW  = $clog2(NPINS + 1);
    localparam int PCW = ((RW > CW) ? RW : CW) + 1;

    logic [RW-1:0] rank [NPINS];

    // Rank each pin by the number of common pins below it.
    always_comb begin
        logic [RW-1:0] acc;
        acc = '0;
        for (int i = 0; i < NPINS; i++) begin
            rank[i] = acc;
            acc     = acc + RW'(pin_is_com[i]);
        end
    end

    for (genvar gi = 0; gi < NPINS; gi++) begin : g_pin
        logic [MAXCOM-1:0] row;
        logic              com_sel;
        logic              pix;
        lvl_e              lv;

        assign row     = active[gi*MAXCOM +: MAXCOM];
        assign com_sel = (PCW'(rank[gi]) == PCW'(phase)) &&
                         (PCW'(rank[gi]) <= PCW'(com_last));
        assign pix     = row[phase] ^ invert;
        assign lv      = pin_is_com[gi] ? com_level(com_sel, pol)
                                        : seg_level(pix, pol);
        assign pin_level[gi*LVL_W +: LVL_W] = lv;
    end

endmodule

// File: rtl/lcd_mux_seq.sv
// Top level of the multiplexed LCD drive sequencer: timebase, frame buffer
// and per-pin level selection.
// Assumes: MAXCOM is a power of two, at most 16.
module lcd_mux_seq
    import lcdseq_pkg::*;
#(
    parameter int NPINS  = 8,
    parameter int MAXCOM = 16,
    parameter int PW     = 16,
    localparam int CW    = (MAXCOM > 1) ? $clog2(MAXCOM) : 1,
    localparam int FB    = NPINS * MAXCOM
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NPINS-1:0]       pin_is_com,
    input  logic [CW-1:0]          com_last,
    input  logic [PW-1:0]          prescale,
    input  logic                   invert,
    input  logic                   data_ack,
    input  logic [FB-1:0]          frame_data,
    output logic [NPINS*LVL_W-1:0] pin_level,
    output logic [CW-1:0]          phase,
    output logic                   polarity,
    output logic                   data_req,
    output logic                   underrun
);

    logic          frame_end;
    logic [FB-1:0] active;

    lcdseq_timebase #(.CW(CW), .PW(PW)) u_tb (
        .clk       (clk),
        .rst_n     (rst_n),
        .com_last  (com_last),
        .prescale  (prescale),
        .phase     (phase),
        .pol       (polarity),
        .frame_end (frame_end)
    );

    lcdseq_framebuf #(.FB(FB)) u_fb (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_end  (frame_end),
        .data_ack   (data_ack),
        .frame_data (frame_data),
        .active     (active),
        .data_req   (data_req),
        .underrun   (underrun)
    );

    lcdseq_pindrive #(.NPINS(NPINS), .MAXCOM(MAXCOM), .CW(CW)) u_pd (
        .pin_is_com (pin_is_com),
        .com_last   (com_last),
        .phase      (phase),
        .pol        (polarity),
        .invert     (invert),
        .active     (active),
        .pin_level  (pin_level)
    );

endmodule

// File: rtl/lcdseq_checker.sv
// Temporal checks on the sequencer, attached to every lcd_mux_seq by bind.
module lcdseq_checker #(
    parameter int NPINS = 8,
    parameter int CW    = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               frame_end,
    input logic [CW-1:0]      phase,
    input logic               polarity,
    input logic               data_req,
    input logic               data_ack,
    input logic               underrun,
    input logic [NPINS*3-1:0] pin_level
);

    a_r2_phase_wraps: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |=> (phase == '0));

    a_r3_pol_steady: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_end |=> $stable(polarity));

    a_r3_pol_flips: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |=> (polarity != $past(polarity)));

    a_r7_req_raised: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |=> data_req);

    a_r7_req_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (data_req && !data_ack && !frame_end) |=> data_req);

    a_r9_underrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        underrun |=> underrun);

    for (genvar g = 0; g < NPINS; g++) begin : g_rng
        a_r4_level_code_valid: assert property (@(posedge clk) disable iff (!rst_n)
            pin_level[g*3 +: 3] <= 3'd5);
    end

endmodule

bind lcd_mux_seq lcdseq_checker #(.NPINS(NPINS), .CW(CW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .frame_end (frame_end),
    .phase     (phase),
    .polarity  (polarity),
    .data_req  (data_req),
    .data_ack  (data_ack),
    .underrun  (underrun),
    .pin_level (pin_level)
);

// File: tb/sim_lcd_mux_seq.sv
// Directed bench for lcd_mux_seq: one task per scenario.
module sim_lcd_mux_seq;

    localparam int NP = 8;
    localparam int MC = 16;
    localparam int PW = 16;

    localparam logic [NP*MC-1:0] FR_A = 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210;
    localparam logic [NP*MC-1:0] FR_B = 128'hF0F0_1234_AAAA_5555_0FF0_C3C3_9669_BEEF;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NP-1:0]   pin_is_com = 8'b0000_0111;
    logic [3:0]      com_last = 4'd3;
    logic [PW-1:0]   prescale = 16'd2;
    logic            invert = 1'b0;
    logic            data_ack = 1'b0;
    logic [NP*MC-1:0] frame_data = FR_A;
    logic [NP*3-1:0] pin_level;
    logic [3:0]      phase;
    logic            polarity;
    logic            data_req;
    logic            underrun;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  auto_en = 1'b0;
    bit  done = 1'b0;

    always #4 clk = ~clk;

    lcd_mux_seq #(.NPINS(NP), .MAXCOM(MC), .PW(PW)) u0 (
        .clk(clk), .rst_n(rst_n), .pin_is_com(pin_is_com), .com_last(com_last),
        .prescale(prescale), .invert(invert), .data_ack(data_ack),
        .frame_data(frame_data), .pin_level(pin_level), .phase(phase),
        .polarity(polarity), .data_req(data_req), .underrun(underrun)
    );

    // Acknowledge responder: answers each request with a one-cycle pulse.
    initial forever begin
        @(negedge clk);
        if (data_ack) data_ack = 1'b0;
        else if (auto_en && data_req) data_ack = 1'b1;
    end

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    // Expected level for one pin from the R4/R5/R6 rules.
    function automatic int exp_lvl(input int p, input logic [NP*MC-1:0] fr);
        int  rk;
        bit  sel, on;
        if (pin_is_com[p]) begin
            rk = 0;
            for (int j = 0; j < p; j++) rk += int'(pin_is_com[j]);
            sel = (rk == int'(phase)) && (rk <= int'(com_last));
            return !polarity ? (sel ? 0 : 4) : (sel ? 5 : 1);
        end
        on = fr[p*MC + int'(phase)] ^ invert;
        return !polarity ? (on ? 5 : 3) : (on ? 0 : 2);
    endfunction

    task automatic chk_pins(input string ctx, input logic [NP*MC-1:0] fr);
        for (int p = 0; p < NP; p++)
            check(pin_is_com[p] ? {ctx, "/R4 common"} : {ctx, "/R5 segment"},
                  int'(pin_level[p*3 +: 3]), exp_lvl(p, fr));
    endtask

    task automatic wait_pol_change();
        logic old;
        int   k;
        old = polarity;
        k = 0;
        while (polarity == old && k < 2000) begin @(negedge clk); k++; end
    endtask

    task automatic wait_phase_change();
        logic [3:0] old;
        int k;
        old = phase;
        k = 0;
        while (phase == old && k < 2000) begin @(negedge clk); k++; end
    endtask

    // R1: state straight out of reset.
    task automatic t_reset();
        check("R1 phase", int'(phase), 0);
        check("R1 polarity", int'(polarity), 0);
        check("R1 data_req", int'(data_req), 1);
        check("R1 underrun", int'(underrun), 0);
        chk_pins("R1", '0);
    endtask

    // R7/R8: shadowed data appears only at the following boundary.
    task automatic t_dbuf();
        auto_en = 1'b1;
        repeat (3) @(negedge clk);
        chk_pins("R8 before boundary", '0);
        wait_pol_change();
        chk_pins("R8 first frame", FR_A);
        check("R7 req after boundary", int'(data_req), 1);
        frame_data = FR_B;
        @(negedge clk);
        check("R7 req dropped after ack", int'(data_req), 0);
        repeat (2) @(negedge clk);
        chk_pins("R8 still old frame", FR_A);
        wait_pol_change();
        chk_pins("R8 new frame", FR_B);
    endtask

    // R4/R5: walk two frames, both polarities.
    task automatic t_levels();
        repeat (24) begin @(negedge clk); chk_pins("R5 scan", FR_B); end
    endtask

    // R2/R3: phase timing and polarity period.
    task automatic t_period();
        int n;
        wait_phase_change();
        n = 0; wait_phase_change_count(n);
        check("R2 phase period ps=2", n, 3);
        prescale = 16'd4;
        wait_pol_change(); wait_pol_change();
        wait_phase_change();
        n = 0; wait_phase_change_count(n);
        check("R2 phase period ps=4", n, 5);
        while (phase != 4'd3) @(negedge clk);
        wait_phase_change();
        check("R2 wrap to zero", int'(phase), 0);
        n = 0;
        begin
            logic old;
            old = polarity;
            while (polarity == old && n < 2000) begin @(negedge clk); n++; end
        end
        check("R3 polarity period", n, 20);
    endtask

    task automatic wait_phase_change_count(inout int n);
        logic [3:0] old;
        old = phase;
        while (phase == old && n < 2000) begin @(negedge clk); n++; end
    endtask

    // R4: non-contiguous commons, one ranked beyond com_last.
    task automatic t_noncontig();
        pin_is_com = 8'b0010_0011;
        com_last = 4'd1;
        wait_pol_change();
        repeat (20) begin @(negedge clk); chk_pins("R4 remap", FR_B); end
        pin_is_com = 8'b0000_0111;
        com_last = 4'd3;
        wait_pol_change();
    endtask

    // R6: invert complements segments only.
    task automatic t_invert();
        invert = 1'b1;
        repeat (8) begin @(negedge clk); chk_pins("R6 invert", FR_B); end
        invert = 1'b0;
        @(negedge clk);
        chk_pins("R6 invert off", FR_B);
    endtask

    // R9: missed fetch keeps the image and sets the sticky flag.
    task automatic t_underrun();
        wait_pol_change();
        @(negedge clk);
        auto_en = 1'b0;
        frame_data = FR_A;
        wait_pol_change();
        check("R9 no underrun with buffered frame", int'(underrun), 0);
        chk_pins("R9 buffered frame shown", FR_B);
        wait_pol_change();
        check("R9 underrun set", int'(underrun), 1);
        chk_pins("R9 old frame kept", FR_B);
        auto_en = 1'b1;
        wait_pol_change();
        wait_pol_change();
        chk_pins("R9 recovery frame", FR_A);
        check("R9 underrun sticky", int'(underrun), 1);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_dbuf();
        t_levels();
        t_period();
        t_noncontig();
        t_invert();
        t_underrun();
        done = 1'b1;
        summary();
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

endmodule